// File: doc/BRIEF.md
# DMA Channel Submission and Interrupt Controller

This block is the control side of one DMA channel. Software programs a small register port. It enables the channel, writes a one to a submit bit to hand a transfer to the engine, and reads back which transfer identifiers have finished. Each accepted submission receives a rolling 2-bit identifier. The identifier goes to the engine over a valid/ready push handshake, together with a flag that marks the transfer as repeating (cyclic). The engine later reports each finished transfer by identifier, with a flag that says the transfer ended early (partial).

Two events feed an interrupt register set: "submission accepted" and "transfer finished". Each event is always recorded in a source register. A mask register, where 1 means blocked, decides whether a recorded event reaches the pending view and the single interrupt line. Software acknowledges events by writing ones to either the source address or the pending address.

Register word addresses: 0 control (bit0 enable, bit1 cyclic), 1 submit (bit0), 2 next ID, 3 active ID, 4 done bitmap (bits 3:0 one per ID, bit 31 partial-seen), 5 mask, 6 pending, 7 source. In the three interrupt registers, bit0 is the queued event and bit1 is the finished event. Reads are combinational from the read address.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: A write of 1 to bit0 of address 1 while enabled sets the submit bit. While it is set, push_valid is high with push_id equal to the next ID. It stays set for as long as push_ready is low.
- R2: A write of 0 to the submit bit, a write of 1 while it is already set, or any submit write while the channel is disabled leaves the submit bit and the next ID unchanged.
- R3: Clearing enable (bit0 of address 0) drops push_valid and clears a pending submit bit. It also discards all outstanding transfers, so the active ID becomes equal to the next ID.
- R4: On an accepted push (push_valid and push_ready at one edge), the submit bit reads 0 afterwards, the next ID advances by one modulo 4, and the done bit of the pushed ID is cleared.
- R5: At most 4 transfers are outstanding. With 4 outstanding, push_valid stays low and the submit bit stays set.
- R6: A completion report while at least one transfer is outstanding, for a non-cyclic transfer, sets the done bit of cmpl_id and advances the active ID. Whenever nothing is outstanding, the active ID equals the next ID.
- R7: The queued event (bit0) fires whenever the submit bit falls from 1 to 0. The finished event (bit1) fires on every accepted completion report, whatever the partial flag.
- R8: Events are recorded in the source register (address 7) regardless of the mask, and a bit that is already set stays set.
- R9: The mask (address 5) resets to 3. Pending (address 6) reads source AND NOT mask, and irq is high exactly when any pending bit is 1.
- R10: Writing 1s to address 6 or address 7 clears the corresponding source bits, and several bits can be cleared in one write. Writing 0 bits leaves them unchanged.
- R11: If a hardware event and a clear of the same bit land in the same cycle, the bit ends set.
- R12: A transfer pushed with the cyclic flag (bit1 of address 0) set produces no finished event, no done bit and no advance of the active ID when a completion report names it.
- R13: An accepted completion with cmpl_partial high sets done-register bit 31. That bit clears when the channel is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register write word address |
| reg_wr_data | input | 2 | Register write data (all writable fields fit in 2 bits) |
| reg_rd_addr | input | 3 | Register read word address |
| reg_rd_data | output | DATA_W | Register read data, combinational |
| push_valid | output | 1 | Transfer offered to the engine |
| push_id | output | ID_W | Identifier of the offered transfer |
| push_cyclic | output | 1 | Offered transfer repeats |
| push_ready | input | 1 | Engine accepts the offered transfer |
| cmpl_valid | input | 1 | Engine reports a finished transfer |
| cmpl_id | input | ID_W | Identifier of the finished transfer |
| cmpl_partial | input | 1 | Finished transfer ended early |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a full set of four outstanding transfers with a fifth submission waiting. From there, the bench has to show that the held submission is withdrawn by a disable rather than by a push. The bench reaches this state by keeping the engine ready and issuing four back-to-back submissions without reporting any completion. It then adds a fifth submission and clears enable. This is also how the identifier wrap from 3 to 0 and the done-bit clearing of an ID reused in the next round are exercised. A separate cycle drives a completion report and a write-one-to-clear of the same source bit on one edge to show that the event takes priority.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
  localparam int ADDR_W = 3;
  localparam int WR_W   = 2;
  localparam int EV_W   = 2;
  localparam int EV_QUEUED   = 0;
  localparam int EV_FINISHED = 1;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL      = 3'd0,
    RA_SUBMIT    = 3'd1,
    RA_NEXT_ID   = 3'd2,
    RA_ACTIVE_ID = 3'd3,
    RA_DONE      = 3'd4,
    RA_IRQ_MASK  = 3'd5,
    RA_IRQ_PEND  = 3'd6,
    RA_IRQ_SRC   = 3'd7
  } reg_addr_e;

  // Acknowledge first, then let new events win.
  function automatic logic [EV_W-1:0] w1c_next(input logic [EV_W-1:0] cur,
                                               input logic [EV_W-1:0] clr,
                                               input logic [EV_W-1:0] ev);
    return (cur & ~clr) | ev;
  endfunction

  function automatic logic [EV_W-1:0] pend_of(input logic [EV_W-1:0] src,
                                              input logic [EV_W-1:0] mask);
    return src & ~mask;
  endfunction
endpackage

// File: rtl/dma_submit_ctl.sv
module dma_submit_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic set_req,
  input  logic q_full,
  input  logic push_ready,
  output logic submit,
  output logic push_valid,
  output logic push_fire,
  output logic ev_queued
);
  logic submit_d;

  assign push_valid = submit & enable & ~q_full;
  assign push_fire  = push_valid & push_ready;

  always_comb begin
    submit_d = submit;
    if (!enable)        submit_d = 1'b0;
    else if (push_fire) submit_d = 1'b0;
    else if (set_req)   submit_d = 1'b1;
  end

  assign ev_queued = submit & ~submit_d;

  always_ff @(posedge clk) begin
    if (!rst_n) submit <= 1'b0;
    else        submit <= submit_d;
  end
endmodule

// File: rtl/dma_id_track.sv
module dma_id_track #(
  parameter int ID_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic                  push_fire,
  input  logic                  push_cyclic,
  input  logic                  cmpl_valid,
  input  logic [ID_W-1:0]       cmpl_id,
  input  logic                  cmpl_partial,
  output logic [ID_W-1:0]       next_id,
  output logic [ID_W-1:0]       active_id,
  output logic [(1<<ID_W)-1:0]  done,
  output logic                  q_full,
  output logic                  idle,
  output logic                  partial_seen,
  output logic                  cmpl_acc
);
  localparam int NIDS  = 1 << ID_W;
  localparam int CNT_W = ID_W + 1;

  logic [CNT_W-1:0] outstanding;
  logic [NIDS-1:0]  cyc_tag;

  assign q_full   = (outstanding == CNT_W'(NIDS));
  assign idle     = (outstanding == '0);
  assign cmpl_acc = cmpl_valid & enable & ~idle & ~cyc_tag[cmpl_id];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outstanding  <= '0;
      next_id      <= '0;
      active_id    <= '0;
      cyc_tag      <= '0;
      partial_seen <= 1'b0;
    end else if (!enable) begin
      outstanding  <= '0;
      active_id    <= next_id;
      partial_seen <= 1'b0;
    end else begin
      outstanding <= outstanding + CNT_W'(push_fire) - CNT_W'(cmpl_acc);
      if (push_fire) begin
        next_id          <= next_id + 1'b1;
        cyc_tag[next_id] <= push_cyclic;
      end
      if (cmpl_acc) begin
        active_id <= active_id + 1'b1;
        if (cmpl_partial) partial_seen <= 1'b1;
      end
    end
  end

  for (genvar gi = 0; gi < NIDS; gi++) begin : g_done
    always_ff @(posedge clk) begin
      if (!rst_n)                                     done[gi] <= 1'b0;
      else if (push_fire && next_id == ID_W'(gi))     done[gi] <= 1'b0;
      else if (cmpl_acc && cmpl_id == ID_W'(gi))      done[gi] <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_irq_set.sv
module dma_irq_set
  import dma_ctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_W-1:0] ev,
  input  logic [EV_W-1:0] clr,
  input  logic            mask_we,
  input  logic [EV_W-1:0] mask_wdata,
  output logic [EV_W-1:0] src,
  output logic [EV_W-1:0] mask,
  output logic [EV_W-1:0] pend,
  output logic            irq
);
  assign pend = pend_of(src, mask);
  assign irq  = |pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src  <= '0;
      mask <= '1;
    end else begin
      src <= w1c_next(src, clr, ev);
      if (mask_we) mask <= mask_wdata;
    end
  end
endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
  import dma_ctl_pkg::*;
#(
  parameter int ID_W   = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_wr_addr,
  input  logic [WR_W-1:0]   reg_wr_data,
  input  logic [ADDR_W-1:0] reg_rd_addr,
  output logic [DATA_W-1:0] reg_rd_data,
  output logic              push_valid,
  output logic [ID_W-1:0]   push_id,
  output logic              push_cyclic,
  input  logic              push_ready,
  input  logic              cmpl_valid,
  input  logic [ID_W-1:0]   cmpl_id,
  input  logic              cmpl_partial,
  output logic              irq
);
  localparam int NIDS = 1 << ID_W;

  logic            enable_q, cyclic_q;
  logic            submit_q, push_fire, ev_queued, ev_finished;
  logic            q_full, idle, partial_seen;
  logic [ID_W-1:0] next_id, active_id;
  logic [NIDS-1:0] done;
  logic [EV_W-1:0] irq_src, irq_mask, irq_pend, ev_vec, clr_vec;
  logic            wr_ctrl, wr_submit, wr_mask, wr_ack;

  assign wr_ctrl   = reg_wr_en && reg_wr_addr == RA_CTRL;
  assign wr_submit = reg_wr_en && reg_wr_addr == RA_SUBMIT;
  assign wr_mask   = reg_wr_en && reg_wr_addr == RA_IRQ_MASK;
  assign wr_ack    = reg_wr_en && (reg_wr_addr == RA_IRQ_SRC || reg_wr_addr == RA_IRQ_PEND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q <= 1'b0;
      cyclic_q <= 1'b0;
    end else if (wr_ctrl) begin
      enable_q <= reg_wr_data[0];
      cyclic_q <= reg_wr_data[1];
    end
  end

  dma_submit_ctl u_submit (
    .clk(clk), .rst_n(rst_n), .enable(enable_q),
    .set_req(wr_submit && reg_wr_data[0]), .q_full(q_full),
    .push_ready(push_ready), .submit(submit_q), .push_valid(push_valid),
    .push_fire(push_fire), .ev_queued(ev_queued)
  );

  dma_id_track #(.ID_W(ID_W)) u_ids (
    .clk(clk), .rst_n(rst_n), .enable(enable_q), .push_fire(push_fire),
    .push_cyclic(cyclic_q), .cmpl_valid(cmpl_valid), .cmpl_id(cmpl_id),
    .cmpl_partial(cmpl_partial), .next_id(next_id), .active_id(active_id),
    .done(done), .q_full(q_full), .idle(idle), .partial_seen(partial_seen),
    .cmpl_acc(ev_finished)
  );

  assign ev_vec  = {ev_finished, ev_queued};
  assign clr_vec = wr_ack ? reg_wr_data : '0;

  dma_irq_set u_irq (
    .clk(clk), .rst_n(rst_n), .ev(ev_vec), .clr(clr_vec),
    .mask_we(wr_mask), .mask_wdata(reg_wr_data),
    .src(irq_src), .mask(irq_mask), .pend(irq_pend), .irq(irq)
  );

  assign push_id     = next_id;
  assign push_cyclic = cyclic_q;

  always_comb begin
    reg_rd_data = '0;
    case (reg_rd_addr)
      RA_CTRL:      reg_rd_data[1:0]      = {cyclic_q, enable_q};
      RA_SUBMIT:    reg_rd_data[0]        = submit_q;
      RA_NEXT_ID:   reg_rd_data[ID_W-1:0] = next_id;
      RA_ACTIVE_ID: reg_rd_data[ID_W-1:0] = active_id;
      RA_DONE: begin
        reg_rd_data[NIDS-1:0] = done;
        reg_rd_data[DATA_W-1] = partial_seen;
      end
      RA_IRQ_MASK:  reg_rd_data[EV_W-1:0] = irq_mask;
      RA_IRQ_PEND:  reg_rd_data[EV_W-1:0] = irq_pend;
      default:      reg_rd_data[EV_W-1:0] = irq_src;
    endcase
  end
endmodule

// File: rtl/dma_ctl_chk.sv
module dma_ctl_chk #(
  parameter int ID_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            enable_q,
  input logic            submit_q,
  input logic            push_valid,
  input logic            push_ready,
  input logic [ID_W-1:0] next_id,
  input logic [ID_W-1:0] active_id,
  input logic            idle,
  input logic            q_full,
  input logic            ev_queued,
  input logic            ev_finished,
  input logic [1:0]      irq_src,
  input logic [1:0]      irq_mask,
  input logic            irq
);
  // R1
  submit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (submit_q && enable_q && !push_ready) |=> submit_q);

  // R3
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_q |=> !submit_q);

  // R3
  abort_nopush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_q |-> !push_valid);

  // R4
  next_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_ready) |=> next_id == $past(next_id) + 1'b1);

  // R5
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !push_valid);

  // R6
  idle_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> active_id == next_id);

  // R8
  queued_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_queued |=> irq_src[0]);

  // R8
  finished_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_finished |=> irq_src[1]);

  // R9
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == 2'b11) |-> !irq);
endmodule

bind dma_xfer_ctrl dma_ctl_chk #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable_q(enable_q), .submit_q(submit_q),
  .push_valid(push_valid), .push_ready(push_ready), .next_id(next_id),
  .active_id(active_id), .idle(idle), .q_full(q_full),
  .ev_queued(ev_queued), .ev_finished(ev_finished),
  .irq_src(irq_src), .irq_mask(irq_mask), .irq(irq)
);

// File: tb/tb_dma_xfer_ctrl.sv
module tb_dma_xfer_ctrl;
  localparam int ID_W = 2;
  localparam int DW   = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [1:0]    wr_data = '0;
  logic [2:0]    rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          push_valid, push_cyclic, irq;
  logic [ID_W-1:0] push_id;
  logic          push_ready = 1'b1;
  logic          cmpl_valid = 1'b0;
  logic [ID_W-1:0] cmpl_id = '0;
  logic          cmpl_partial = 1'b0;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  localparam logic [2:0] A_CTRL = 3'd0, A_SUB = 3'd1, A_NEXT = 3'd2, A_ACT = 3'd3,
                         A_DONE = 3'd4, A_MASK = 3'd5, A_PEND = 3'd6, A_SRC = 3'd7;

  always #2.5 clk = ~clk;

  dma_xfer_ctrl #(.ID_W(ID_W), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_wr_addr(wr_addr),
    .reg_wr_data(wr_data), .reg_rd_addr(rd_addr), .reg_rd_data(rd_data),
    .push_valid(push_valid), .push_id(push_id), .push_cyclic(push_cyclic),
    .push_ready(push_ready), .cmpl_valid(cmpl_valid), .cmpl_id(cmpl_id),
    .cmpl_partial(cmpl_partial), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [DW-1:0] exp, input string tag);
    rd_addr = a;
    #0.5;
    check(rd_data == exp, tag, rd_data, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic complete(input logic [ID_W-1:0] id, input logic part);
    @(negedge clk);
    cmpl_valid = 1'b1; cmpl_id = id; cmpl_partial = part;
    @(negedge clk);
    cmpl_valid = 1'b0; cmpl_partial = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000 && !finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] exp_done;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state (R9 mask resets to 3)
    rd_chk(A_NEXT, 0, "R4 reset next id");
    rd_chk(A_ACT, 0, "R6 reset active id");
    rd_chk(A_DONE, 0, "R6 reset done");
    rd_chk(A_MASK, 3, "R9 reset mask");
    rd_chk(A_SRC, 0, "R8 reset source");
    rd_chk(A_SUB, 0, "R1 reset submit");
    check(!irq && !push_valid, "R9 reset irq/push", {irq, push_valid}, 0);

    // R2: submit while disabled ignored
    wr(A_SUB, 1);
    rd_chk(A_SUB, 0, "R2 submit while disabled");

    // R1: held while engine not ready
    push_ready = 1'b0;
    wr(A_CTRL, 1);
    wr(A_SUB, 1);
    check(push_valid && push_id == 0, "R1 push offered", {push_valid, push_id}, 3'b100);
    repeat (3) @(negedge clk);
    rd_chk(A_SUB, 1, "R1 submit held while not ready");
    wr(A_SUB, 0);
    rd_chk(A_SUB, 1, "R2 write zero ignored");
    wr(A_SUB, 1);
    rd_chk(A_NEXT, 0, "R2 second set ignored");

    // R4/R7/R8/R9: accepted push while masked
    push_ready = 1'b1;
    @(negedge clk);
    rd_chk(A_SUB, 0, "R4 submit clears on push");
    rd_chk(A_NEXT, 1, "R4 next advances");
    rd_chk(A_SRC, 1, "R8 queued recorded while masked");
    rd_chk(A_PEND, 0, "R9 masked pending");
    check(!irq, "R9 masked irq low", irq, 0);
    wr(A_MASK, 0);
    rd_chk(A_PEND, 1, "R9 unmask propagates");
    check(irq, "R9 irq high", irq, 1);

    // R6/R7: completion
    complete(0, 0);
    rd_chk(A_DONE, 1, "R6 done bit 0 set");
    rd_chk(A_SRC, 3, "R7 finished event");
    rd_chk(A_ACT, 1, "R6 active equals next when idle");

    // R10: clear through either register
    wr(A_PEND, 1);
    rd_chk(A_SRC, 2, "R10 clear via pending");
    wr(A_SRC, 2);
    rd_chk(A_SRC, 0, "R10 clear via source");
    check(!irq, "R9 irq low after clear", irq, 0);

    // R11: event beats same-cycle clear
    wr(A_SUB, 1);
    @(negedge clk);
    wr(A_SRC, 3);
    @(negedge clk);
    cmpl_valid = 1'b1; cmpl_id = 1;
    wr_en = 1'b1; wr_addr = A_SRC; wr_data = 2'b10;
    @(negedge clk);
    cmpl_valid = 1'b0; wr_en = 1'b0;
    rd_chk(A_SRC, 2, "R11 event wins over clear");
    rd_chk(A_DONE, 3, "R6 done bit 1 set");

    // R10 multi-bit clear
    wr(A_SUB, 1);
    @(negedge clk);
    rd_chk(A_SRC, 3, "R8 both recorded");
    wr(A_PEND, 3);
    rd_chk(A_SRC, 0, "R10 multi-bit clear");
    complete(2, 0);
    wr(A_SRC, 3);
    exp_done = 7;
    rd_chk(A_DONE, exp_done, "R6 done after three");

    // R4/R5 sweep: four pushes with wrap
    for (int k = 0; k < 4; k++) begin
      int id;
      id = (3 + k) % 4;
      wr(A_SUB, 1);
      @(negedge clk);
      exp_done[id] = 1'b0;
      rd_chk(A_NEXT, (id + 1) % 4, "R4 sweep next id");
      rd_chk(A_DONE, exp_done, "R4 sweep done cleared");
    end
    wr(A_SUB, 1);
    @(negedge clk);
    rd_chk(A_SUB, 1, "R5 submit held when full");
    check(!push_valid, "R5 no push when full", push_valid, 0);
    rd_chk(A_NEXT, 3, "R5 next unchanged when full");

    // R3 abort on disable
    wr(A_SRC, 3);
    wr(A_CTRL, 0);
    @(negedge clk);
    rd_chk(A_SUB, 0, "R3 abort clears submit");
    rd_chk(A_ACT, 3, "R3 active equals next after flush");
    rd_chk(A_SRC, 1, "R7 queued event on abort");
    check(!push_valid, "R3 no push while disabled", push_valid, 0);

    // R6/R13 completion sweep
    wr(A_CTRL, 1);
    wr(A_SRC, 3);
    for (int k = 0; k < 4; k++) begin
      int id;
      id = (3 + k) % 4;
      wr(A_SUB, 1);
      @(negedge clk);
      complete(id[ID_W-1:0], k == 2);
      exp_done[id] = 1'b1;
      rd_chk(A_ACT, (id + 1) % 4, "R6 sweep active advances");
      rd_chk(A_DONE, exp_done | (k >= 2 ? 32'h8000_0000 : 0), "R13 sweep done bits");
      rd_chk(A_SRC, 3, "R7 finished regardless of partial");
      wr(A_SRC, 3);
    end
    wr(A_CTRL, 0);
    @(negedge clk);
    rd_chk(A_DONE, 15, "R13 partial cleared on disable");

    // R12 cyclic
    wr(A_CTRL, 3);
    wr(A_SRC, 3);
    wr(A_SUB, 1);
    @(negedge clk);
    rd_chk(A_NEXT, 0, "R12 cyclic pushed");
    exp_done = 7;
    rd_chk(A_DONE, exp_done, "R4 cyclic id done cleared");
    complete(3, 0);
    rd_chk(A_DONE, exp_done, "R12 no done bit for cyclic");
    rd_chk(A_SRC, 1, "R12 no finished event for cyclic");
    rd_chk(A_ACT, 3, "R12 active held by cyclic");
    wr(A_CTRL, 0);
    @(negedge clk);
    rd_chk(A_ACT, 0, "R3 cyclic flushed on disable");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule